// File: doc/BRIEF.md
# I2C-Controlled Crosspoint Register Bank

This block is the control side of a four-input, four-output analog crosspoint switch. It listens on a two-wire serial bus as a write-only slave and keeps the settings that steer the analog path. For each output it holds an input selection, a gain choice and an enable. For the first two inputs it holds a clamp enable. It also drives two general-purpose logic levels that a board can use to switch an audio path alongside the video. The analog stages are outside this block. Nothing can be read back.

The bus clock and data lines are sampled on a faster system clock after synchronizer flops. START and STOP are found as data edges while the clock is high. The 7-bit device address is the fixed high nibble `1001` followed by the three strap pins. The all-ones strap pattern turns the bus interface off and raises a mode flag, so that a board can drive the switch by other means. A transfer carries the address byte, then a subaddress byte that picks one of three registers, then any number of data bytes. The register pointer advances after each data byte and wraps from the third register back to the first.

Top module: `xpt_ctrl_regs`

## Requirements
- R1: The block acknowledges only the address byte `{1001, strap[2:0], 0}`. A byte with a different address, or with bit 0 = 1 (read), is not acknowledged, and no later byte is acknowledged or written until the next START.
- R2: When strap = 3'b111, `bus_off` is 1, the block never pulls SDA low and no register changes. For every other strap pattern `bus_off` is 0.
- R3: After a matching address byte, SDA is pulled low (`sda_pull` = 1) for the ninth clock of that byte, of the subaddress byte and of every data byte.
- R4: Only subaddress bits [1:0] matter: 0 picks the switch register, 1 the gain/clamp/aux register, 2 the enable register, and 3 is treated as 0.
- R5: Each data byte after the subaddress goes to the current register, then the pointer steps 0→1→2→0.
- R6: Switch register bits [2j+1:2j] appear on `in_sel[2j+1:2j]` and give the input number (0 to 3) for output j.
- R7: In the gain/clamp/aux register, bit 4+j drives `gain_unity[j]` (1 = gain 1, 0 = gain 2), bit 3 = 0 sets `clamp_en[1]`, bit 2 = 0 sets `clamp_en[0]`, and bits [1:0] drive `aux[1:0]`.
- R8: Enable register bit j drives `out_en[j]` (1 = output j driven, 0 = high impedance). Bits 7:4 have no effect.
- R9: After reset, `out_en` = 0, `aux` = 0, `in_sel` = 0, `gain_unity` = 0, `clamp_en` = 2'b11 and `sda_pull` = 0.
- R10: A repeated START begins a new address phase. After a STOP, bytes that are clocked without a new START are ignored.
- R11: A register changes only in the cycle in which the acknowledge of its data byte begins. A byte cut short by a STOP writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap | input | 3 | Address strap pins; 3'b111 turns the bus off |
| sda_pull | output | 1 | 1 = pull the data line low (acknowledge) |
| in_sel | output | 8 | Input choice, two bits per output |
| gain_unity | output | 4 | Per output: 1 = gain 1, 0 = gain 2 |
| clamp_en | output | 2 | Clamp enable for inputs 1 and 0 |
| aux | output | 2 | Auxiliary logic levels |
| out_en | output | 4 | Per-output drive enable |
| bus_off | output | 1 | Bus control is turned off by the straps |

## Verification
The bench builds the block with its defaults: address nibble `1001` and two synchronizer stages. The bus runs at a tenth of the system clock rate per quarter bit, so every edge passes through both flops well before the next one. Because the straps are a run-time input, one build covers the plain pattern, a second matching address, and the all-ones pattern that turns the bus off. Within that build the bench reaches pointer wrap, subaddress 3 and upper-bit masking, repeated START, bytes sent without a START, and a byte aborted by a STOP.

// File: rtl/xpt_ctrl_regs.sv
module xpt_ctrl_regs #(
  parameter logic [3:0] ADDR_HI = 4'b1001,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap,
  output logic       sda_pull,
  output logic [7:0] in_sel,
  output logic [3:0] gain_unity,
  output logic [1:0] clamp_en,
  output logic [1:0] aux,
  output logic [3:0] out_en,
  output logic       bus_off
);

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_SUB, PH_DATA} phase_t;

  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q, scl_s, sda_s;
  logic start_c, stop_c, rise, fall;
  logic [7:0] my_addr;

  phase_t     phase;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [1:0] ptr;
  logic [7:0] sw_r, gco_r, oen_r;
  logic       ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_in};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s   = scl_sr[SYNC_STAGES-1];
  assign sda_s   = sda_sr[SYNC_STAGES-1];
  assign start_c = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise    = scl_s & ~scl_q;
  assign fall    = ~scl_s & scl_q;
  assign my_addr = {ADDR_HI, strap, 1'b0};
  assign bus_off = &strap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bitcnt <= 4'd0;
      shreg  <= 8'h00;
      ptr    <= 2'd0;
      ack    <= 1'b0;
      sw_r   <= 8'h00;
      gco_r  <= 8'h00;
      oen_r  <= 8'h00;
    end else if (bus_off) begin
      phase  <= PH_IDLE;
      bitcnt <= 4'd0;
      ack    <= 1'b0;
    end else if (start_c) begin
      phase  <= PH_ADDR;
      bitcnt <= 4'd0;
      ack    <= 1'b0;
    end else if (stop_c) begin
      phase  <= PH_IDLE;
      bitcnt <= 4'd0;
      ack    <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (rise && bitcnt < 4'd8) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end else if (fall && bitcnt == 4'd8) begin
        bitcnt <= 4'd9;
        case (phase)
          PH_ADDR: begin
            if (shreg == my_addr) ack <= 1'b1;
            else phase <= PH_IDLE;
          end
          PH_SUB: begin
            ack <= 1'b1;
            ptr <= (shreg[1:0] == 2'b11) ? 2'd0 : shreg[1:0];
          end
          default: begin
            ack <= 1'b1;
            case (ptr)
              2'd0:    sw_r  <= shreg;
              2'd1:    gco_r <= shreg;
              default: oen_r <= shreg;
            endcase
            ptr <= (ptr == 2'd2) ? 2'd0 : ptr + 2'd1;
          end
        endcase
      end else if (fall && bitcnt == 4'd9) begin
        ack    <= 1'b0;
        bitcnt <= 4'd0;
        if (phase == PH_ADDR) phase <= PH_SUB;
        else if (phase == PH_SUB) phase <= PH_DATA;
      end
    end
  end

  assign sda_pull   = ack;
  assign in_sel     = sw_r;
  assign gain_unity = gco_r[7:4];
  assign clamp_en   = ~gco_r[3:2];
  assign aux        = gco_r[1:0];
  assign out_en     = oen_r[3:0];

endmodule

// File: rtl/xpt_ctrl_regs_chk.sv
module xpt_ctrl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull,
  input logic [7:0] in_sel,
  input logic [3:0] gain_unity,
  input logic [1:0] clamp_en,
  input logic [1:0] aux,
  input logic [3:0] out_en,
  input logic       bus_off
);

  a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_en == 4'h0 && aux == 2'b00 && !sda_pull));

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |=> !sda_pull);

  a_r11_write_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(in_sel) || !$stable(gain_unity) || !$stable(clamp_en) ||
     !$stable(aux) || !$stable(out_en)) |-> sda_pull);

  a_r3_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |=> sda_pull);

endmodule

bind xpt_ctrl_regs xpt_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .in_sel(in_sel),
  .gain_unity(gain_unity), .clamp_en(clamp_en), .aux(aux),
  .out_en(out_en), .bus_off(bus_off)
);

// File: tb/xpt_ctrl_regs_tb.sv
module xpt_ctrl_regs_tb;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b000;
  logic sda_pull, bus_off;
  logic [7:0] in_sel;
  logic [3:0] gain_unity, out_en;
  logic [1:0] clamp_en, aux;
  wire sda_line = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  xpt_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .strap(strap),
    .sda_pull(sda_pull), .in_sel(in_sel), .gain_unity(gain_unity),
    .clamp_en(clamp_en), .aux(aux), .out_en(out_en), .bus_off(bus_off)
  );

  typedef struct { string req; logic [21:0] val; } item_t;
  item_t exp_q[$];
  item_t obs_q[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [7:0] m_sw = 8'h00, m_gco = 8'h00, m_oen = 8'h00;
  logic m_off = 1'b0;

  always @(negedge clk) begin
    while (obs_q.size() > 0) begin
      item_t o, e;
      o = obs_q.pop_front();
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s got=%h exp=<none>", o.req, o.val);
      end else begin
        e = exp_q.pop_front();
        if (o.val !== e.val) begin
          bad++;
          $display("FAIL %s got=%h exp=%h", e.req, o.val, e.val);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input string req, input logic [21:0] ev, input logic [21:0] ov);
    item_t e, o;
    e.req = req; e.val = ev;
    o.req = req; o.val = ov;
    exp_q.push_back(e);
    obs_q.push_back(o);
  endtask

  function automatic logic [21:0] model_vec();
    return {m_sw, m_gco[7:4], ~m_gco[3], ~m_gco[2], m_gco[1:0], m_oen[3:0], m_off, 1'b0};
  endfunction

  task automatic snap(input string req);
    tick(4);
    push(req, model_vec(), {in_sel, gain_unity, clamp_en, aux, out_en, bus_off, sda_pull});
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    push(req, {21'd0, exp_ack}, {21'd0, ~sda_line});
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic mdl_put(input logic [1:0] p, input logic [7:0] v);
    case (p)
      2'd0: m_sw = v;
      2'd1: m_gco = v;
      default: m_oen = v;
    endcase
  endtask

  task automatic write_regs(input logic [7:0] sub, input logic [7:0] d [4], input int n, input string req);
    logic [1:0] p;
    bus_start();
    send_byte({4'b1001, strap, 1'b0}, 1'b1, "R1");
    send_byte(sub, 1'b1, "R3");
    p = (sub[1:0] == 2'b11) ? 2'd0 : sub[1:0];
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], 1'b1, req);
      mdl_put(p, d[i]);
      p = (p == 2'd2) ? 2'd0 : p + 2'd1;
    end
    bus_stop();
    snap(req);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(3);
    snap("R9");

    write_regs(8'h00, '{8'hE4, 8'h00, 8'h00, 8'h00}, 1, "R6");
    write_regs(8'h01, '{8'hA6, 8'h00, 8'h00, 8'h00}, 1, "R7");
    write_regs(8'h02, '{8'hF5, 8'h00, 8'h00, 8'h00}, 1, "R8");
    write_regs(8'h01, '{8'h0F, 8'h0A, 8'h3C, 8'h1B}, 4, "R5");
    write_regs(8'h03, '{8'h55, 8'h00, 8'h00, 8'h00}, 1, "R4");
    write_regs(8'hFE, '{8'h0F, 8'h00, 8'h00, 8'h00}, 1, "R4");

    bus_start();
    send_byte(8'h92, 1'b0, "R1");
    send_byte(8'h00, 1'b0, "R1");
    send_byte(8'hAA, 1'b0, "R1");
    bus_stop();
    snap("R1");
    bus_start();
    send_byte(8'h91, 1'b0, "R1");
    send_byte(8'h02, 1'b0, "R1");
    send_byte(8'h00, 1'b0, "R1");
    bus_stop();
    snap("R1");

    strap = 3'b101;
    tick(4);
    bus_start();
    send_byte(8'h90, 1'b0, "R1");
    bus_stop();
    write_regs(8'h00, '{8'h1E, 8'h00, 8'h00, 8'h00}, 1, "R1");

    strap = 3'b111;
    m_off = 1'b1;
    snap("R2");
    bus_start();
    send_byte(8'h9E, 1'b0, "R2");
    send_byte(8'h02, 1'b0, "R2");
    send_byte(8'h00, 1'b0, "R2");
    bus_stop();
    snap("R2");
    strap = 3'b000;
    m_off = 1'b0;
    tick(4);

    bus_start();
    send_byte(8'h90, 1'b1, "R10");
    send_byte(8'h02, 1'b1, "R10");
    bus_start();
    send_byte(8'h90, 1'b1, "R10");
    send_byte(8'h00, 1'b1, "R10");
    send_byte(8'h99, 1'b1, "R10");
    m_sw = 8'h99;
    bus_stop();
    snap("R10");

    scl_m = 1'b0; tick(Q);
    send_byte(8'h90, 1'b0, "R10");
    send_byte(8'h02, 1'b0, "R10");
    send_byte(8'h00, 1'b0, "R10");
    bus_stop();
    snap("R10");

    bus_start();
    send_byte(8'h90, 1'b1, "R11");
    send_byte(8'h02, 1'b1, "R11");
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    snap("R11");

    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    m_sw = 8'h00; m_gco = 8'h00; m_oen = 8'h00;
    tick(2);
    snap("R9");

    tick(10);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard left=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule